// File: doc/BRIEF.md
# SPI master per-select timing sequencer

This block is a mode 0 SPI master that moves one 8-bit frame per request and serves four peripheral selects. Each select has its own serial clock divisor, its own settling time between select assertion and the first clock edge, and its own spacing between two frames aimed at it. One shared spacing applies whenever the engine moves from one select to a different one. Peripherals with different speeds and bus release times can therefore share the bus without any reprogramming between frames.

A requester raises `req_valid` with the target select, the byte to send and a keep flag, and holds it until `req_ack` or `req_err` appears. A pending request is taken on the first clock edge at which the engine is idle. The engine becomes idle on the edge that ends the last SCK high phase. A requester that raises its next request in the acknowledge cycle is therefore accepted on the edge right after that. The per-select configuration arrives on flat buses, with select k in bits [8k+7:8k]. Divisor registers that are still zero are refused.

Top module: `spi_seq_master`

## Requirements
- R1: A request whose select has divisor 0 is refused. `req_err` is high for exactly one cycle, in the cycle after acceptance. No select is asserted, SCK does not toggle and `req_ack` stays low.
- R2: For divisor N (1..255), every SCK high phase and every SCK low phase between bits lasts ceil(N/2) module clocks. SCK idles low. The divisor comes from the select named in the request.
- R3: Data moves most significant bit first. MOSI changes only while SCK is low. MISO is sampled on the clock edge that raises SCK.
- R4: `req_ack` is high for exactly one cycle per completed frame: the cycle after the edge of the eighth rising SCK. `req_rdata` holds the full received byte in that cycle.
- R5: After a select is asserted, the first rising SCK comes max(P,1)+ceil(N/2) cycles later, where P is that select's lead delay.
- R6: When the target differs from the previous select (or on the first frame after reset), the old select is released no later than the acceptance edge. The new one is asserted max(G,1) cycles after acceptance, where G is the global switch gap. A pending request after an unkept frame therefore sees a release-to-assert gap of max(G,1)+1 cycles. Two selects are never low together, and none is replaced by another without at least one cycle with all selects high.
- R7: When the target equals the previous select, max(T,1) cycles pass after acceptance, where T is that select's trailing delay. Shifting then starts if the select is still held, or the select is asserted and the lead delay follows if it was released.
- R8: With `req_keep` set, the select stays asserted after the frame, also while idle, until a request for another select is accepted. Without it, the select is released on the edge of the final SCK fall.
- R9: The divisor and lead delay are captured at acceptance. The switch gap and trailing delay are used only at acceptance. Later changes to the configuration inputs do not alter a frame in progress.
- R10: After reset and while idle with nothing held, all `cs_n` are high and SCK is low. At most one `cs_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present, held until ack or err |
| req_sel | input | 2 | Target select index |
| req_wdata | input | 8 | Byte to transmit |
| req_keep | input | 1 | Keep the select asserted after this frame |
| req_ack | output | 1 | One-cycle frame completion |
| req_rdata | output | 8 | Received byte, valid with req_ack |
| req_err | output | 1 | One-cycle refusal (zero divisor) |
| cfg_div | input | 32 | Per-select divisors, 8 bits each |
| cfg_lead | input | 32 | Per-select lead delays (select to first SCK) |
| cfg_trail | input | 32 | Per-select delays between frames on one select |
| cfg_swap_gap | input | 8 | Global gap when changing select |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low selects |

## Verification
The hardest situations to reach are those where a request is already pending at the edge that ends the previous frame. These cover a kept select reused at once, a released select requested again, and a held select abandoned for another. In these cases the delay is counted from a final SCK fall or a release that belongs to the previous frame. The stimulus presents each follow-up request in the very cycle the previous acknowledge appears. The bench then measures the spacing from the last falling SCK or the last release to the next assertion or first rise. Configuration changes made two cycles after acceptance confirm that the captured values are the ones used.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  localparam int CFG_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REFUSE,
    ST_GAP,
    ST_TRAIL,
    ST_LEAD,
    ST_SHIFT
  } st_e;

  // number of module clocks in one SCK half period: ceil(div/2)
  function automatic logic [CFG_W-1:0] half_cycles(input logic [CFG_W-1:0] div);
    return {1'b0, div[CFG_W-1:1]} + {{(CFG_W-1){1'b0}}, div[0]};
  endfunction

  // timer load for a delay field: zero behaves like one cycle
  function automatic logic [CFG_W-1:0] delay_load(input logic [CFG_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  function automatic logic [CFG_W-1:0] half_load(input logic [CFG_W-1:0] div);
    return half_cycles(div) - 1'b1;
  endfunction
endpackage

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          shift_out,
  input  logic          shift_in,
  input  logic          miso,
  output logic          mosi,
  output logic [DW-1:0] rx
);
  logic [DW-1:0] tx_q, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      if (load)           tx_q <= load_val;
      else if (shift_out) tx_q <= {tx_q[DW-2:0], 1'b0};
      if (shift_in)       rx_q <= {rx_q[DW-2:0], miso};
    end
  end

  assign mosi = tx_q[DW-1];
  assign rx   = rx_q;
endmodule

// File: rtl/spi_seq_master.sv
module spi_seq_master
  import spi_seq_pkg::*;
#(
  parameter int NCS = 4,
  parameter int DW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [$clog2(NCS)-1:0] req_sel,
  input  logic [DW-1:0]        req_wdata,
  input  logic                 req_keep,
  output logic                 req_ack,
  output logic [DW-1:0]        req_rdata,
  output logic                 req_err,
  input  logic [NCS*CFG_W-1:0] cfg_div,
  input  logic [NCS*CFG_W-1:0] cfg_lead,
  input  logic [NCS*CFG_W-1:0] cfg_trail,
  input  logic [CFG_W-1:0]     cfg_swap_gap,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NCS-1:0]       cs_n
);
  localparam int CSW = $clog2(NCS);
  localparam int BW  = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  st_e              state_q;
  logic [CSW-1:0]   cur_sel_q, last_sel_q;
  logic             cs_on_q, last_valid_q, keep_q, sck_q, ack_q;
  logic [CFG_W-1:0] div_q, lead_q;
  logic [BW-1:0]    bit_q;

  // selected configuration for the incoming request
  logic [CFG_W-1:0] sel_div, sel_lead, sel_trail;
  assign sel_div   = cfg_div  [req_sel*CFG_W +: CFG_W];
  assign sel_lead  = cfg_lead [req_sel*CFG_W +: CFG_W];
  assign sel_trail = cfg_trail[req_sel*CFG_W +: CFG_W];

  // named internal events
  logic accept, refuse, start_ok, same_sel, t_exp;
  logic rise_ev, fall_ev, last_bit, frame_end;
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign refuse    = accept && (sel_div == '0);
  assign start_ok  = accept && (sel_div != '0);
  assign same_sel  = last_valid_q && (req_sel == last_sel_q);
  assign rise_ev   = (state_q == ST_SHIFT) && t_exp && !sck_q;
  assign fall_ev   = (state_q == ST_SHIFT) && t_exp &&  sck_q;
  assign last_bit  = (bit_q == LAST_BIT);
  assign frame_end = fall_ev && last_bit;

  // timer reload decisions
  logic             t_load;
  logic [CFG_W-1:0] t_val;
  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (start_ok) begin
      t_load = 1'b1;
      t_val  = delay_load(same_sel ? sel_trail : cfg_swap_gap);
    end else if (t_exp) begin
      case (state_q)
        ST_GAP:   begin t_load = 1'b1; t_val = delay_load(lead_q); end
        ST_TRAIL: begin t_load = 1'b1; t_val = cs_on_q ? half_load(div_q) : delay_load(lead_q); end
        ST_LEAD,
        ST_SHIFT: begin t_load = 1'b1; t_val = half_load(div_q); end
        default:  ;
      endcase
    end
  end

  spi_seq_timer #(.W(CFG_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  spi_seq_shifter #(.DW(DW)) i_shifter (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .load_val(req_wdata),
    .shift_out(fall_ev && !last_bit), .shift_in(rise_ev), .miso(miso),
    .mosi(mosi), .rx(req_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cur_sel_q    <= '0;
      last_sel_q   <= '0;
      cs_on_q      <= 1'b0;
      last_valid_q <= 1'b0;
      keep_q       <= 1'b0;
      sck_q        <= 1'b0;
      ack_q        <= 1'b0;
      div_q        <= '0;
      lead_q       <= '0;
      bit_q        <= '0;
    end else begin
      ack_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (refuse) state_q <= ST_REFUSE;
          else if (start_ok) begin
            cur_sel_q <= req_sel;
            keep_q    <= req_keep;
            div_q     <= sel_div;
            lead_q    <= sel_lead;
            if (same_sel) state_q <= ST_TRAIL;
            else begin
              cs_on_q <= 1'b0;
              state_q <= ST_GAP;
            end
          end
        end
        ST_REFUSE: state_q <= ST_IDLE;
        ST_GAP: if (t_exp) begin
          cs_on_q <= 1'b1;
          state_q <= ST_LEAD;
        end
        ST_TRAIL: if (t_exp) begin
          if (cs_on_q) begin
            state_q <= ST_SHIFT;
            bit_q   <= '0;
          end else begin
            cs_on_q <= 1'b1;
            state_q <= ST_LEAD;
          end
        end
        ST_LEAD: if (t_exp) begin
          state_q <= ST_SHIFT;
          bit_q   <= '0;
        end
        ST_SHIFT: begin
          if (rise_ev) begin
            sck_q <= 1'b1;
            if (last_bit) ack_q <= 1'b1;
          end else if (fall_ev) begin
            sck_q <= 1'b0;
            if (frame_end) begin
              state_q      <= ST_IDLE;
              cs_on_q      <= keep_q;
              last_sel_q   <= cur_sel_q;
              last_valid_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NCS; g++) begin : g_sel
    assign cs_n[g] = !(cs_on_q && (cur_sel_q == CSW'(g)));
  end

  assign sck     = sck_q;
  assign req_ack = ack_q;
  assign req_err = (state_q == ST_REFUSE);
endmodule

// File: rtl/spi_seq_master_chk.sv
module spi_seq_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ack,
  input logic           err,
  input logic           sck,
  input logic           mosi,
  input logic [NCS-1:0] cs_n
);
  assert_one_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_sck_needs_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n) |-> !sck);

  assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  assert_ack_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sck && !(&cs_n)));

  assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ack && !sck && $stable(cs_n)));

  assert_mosi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  assert_no_direct_switch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(&cs_n) && !(&$past(cs_n))) |-> (cs_n == $past(cs_n)));
endmodule

bind spi_seq_master spi_seq_master_chk #(.NCS(NCS)) i_chk (
  .clk(clk), .rst_n(rst_n), .ack(req_ack), .err(req_err),
  .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/test_spi_seq_master.sv
module test_spi_seq_master;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_sel = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_keep = 1'b0;
  logic        req_ack, req_err;
  logic [7:0]  req_rdata;
  logic [31:0] cfg_div = '0, cfg_lead = '0, cfg_trail = '0;
  logic [7:0]  cfg_swap_gap = '0;
  logic        sck, mosi;
  logic        miso = 1'b0;
  logic [3:0]  cs_n;

  spi_seq_master #(.NCS(NCS), .DW(8)) i_spi_seq_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
    .req_wdata(req_wdata), .req_keep(req_keep), .req_ack(req_ack),
    .req_rdata(req_rdata), .req_err(req_err), .cfg_div(cfg_div),
    .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_swap_gap(cfg_swap_gap),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // expected-value helpers written from the requirements
  function automatic int half_of(input int n);
    return n / 2 + n % 2;
  endfunction
  function automatic int eff(input int d);
    return (d < 1) ? 1 : d;
  endfunction

  task automatic set_cfg(input int s, input int dv, input int ld, input int tr);
    cfg_div[s*8 +: 8]   = 8'(dv);
    cfg_lead[s*8 +: 8]  = 8'(ld);
    cfg_trail[s*8 +: 8] = 8'(tr);
  endtask

  // port monitor, sampling a quarter period after each rising edge
  int cyc = 0, asserts = 0, t_assert = 0, t_release = 0, hi_len = 0;
  int rises = 0, first_rise = 0, lead_fall = 0, last_fall = 0, last_rise = 0;
  int hi_min = 999, hi_max = 0, lo_min = 999, lo_max = 0, acks = 0;
  logic [7:0] cap = '0, sl_reg = '0;
  logic [3:0] prev_csn = 4'hF;
  logic       prev_sck = 1'b0;

  always begin
    @(posedge clk);
    #(CLK_PERIOD/4);
    cyc++;
    if (rst_n) begin
      if (&prev_csn && !(&cs_n)) begin
        asserts++; t_assert = cyc; hi_len = cyc - t_release;
      end
      if (!(&prev_csn) && &cs_n) t_release = cyc;
      if (sck && !prev_sck) begin
        if (rises == 0) begin
          first_rise = cyc; lead_fall = cyc - last_fall;
        end else begin
          if (cyc - last_fall < lo_min) lo_min = cyc - last_fall;
          if (cyc - last_fall > lo_max) lo_max = cyc - last_fall;
        end
        rises++; last_rise = cyc; cap = {cap[6:0], mosi};
      end
      if (!sck && prev_sck) begin
        if (rises > 0) begin
          if (cyc - last_rise < hi_min) hi_min = cyc - last_rise;
          if (cyc - last_rise > hi_max) hi_max = cyc - last_rise;
        end
        if (rises > 0 && rises < 8) begin
          sl_reg = {sl_reg[6:0], 1'b0}; miso = sl_reg[7];
        end
        last_fall = cyc;
      end
      if (req_ack) acks++;
    end
    prev_csn = cs_n; prev_sck = sck;
  end

  bit got_ack, got_err;

  // issue one request (called at a falling edge); returns in the ack/err cycle
  task automatic xfer(input int s, input logic [7:0] tx, input bit keep,
                      input logic [7:0] srx, input bit mutate);
    int n;
    rises = 0; hi_min = 999; hi_max = 0; lo_min = 999; lo_max = 0;
    asserts = 0; cap = '0; sl_reg = srx; miso = srx[7];
    req_sel = 2'(s); req_wdata = tx; req_keep = keep; req_valid = 1'b1;
    got_ack = 0; got_err = 0; n = 0;
    while (!got_ack && !got_err && n < 5000) begin
      @(negedge clk);
      n++;
      if (mutate && n == 2) set_cfg(s, 9, 20, 0);
      got_ack = req_ack; got_err = req_err;
    end
    req_valid = 1'b0;
  endtask

  task automatic check_frame(input string tag, input logic [7:0] tx,
                             input logic [7:0] srx, input int dv);
    chk({tag, " R4 ack"}, int'(got_ack), 1);
    chk({tag, " R4 rx byte"}, int'(req_rdata), int'(srx));
    chk({tag, " R3 mosi byte"}, int'(cap), int'(tx));
    chk({tag, " R2 rise count"}, rises, 8);
    chk({tag, " R2 high min"}, hi_min, half_of(dv));
    chk({tag, " R2 high max"}, hi_max, half_of(dv));
    chk({tag, " R2 low min"}, lo_min, half_of(dv));
    chk({tag, " R2 low max"}, lo_max, half_of(dv));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset cs_n", int'(cs_n), 15);
    chk("R10 reset sck", int'(sck), 0);
    chk("R4 reset ack", int'(req_ack), 0);
    chk("R1 reset err", int'(req_err), 0);
  endtask

  task automatic t_zero_div();
    xfer(2, 8'h11, 0, 8'h22, 0);
    chk("R1 err seen", int'(got_err), 1);
    chk("R1 no ack", int'(got_ack), 0);
    chk("R1 no assert", asserts, 0);
    idle(4);
    chk("R1 no sck", rises, 0);
    chk("R1 selects idle", int'(cs_n), 15);
  endtask

  task automatic t_basic();
    xfer(0, 8'hA5, 0, 8'h3C, 0);
    check_frame("basic", 8'hA5, 8'h3C, 4);
    chk("R5 lead cs0", first_rise - t_assert, eff(3) + half_of(4));
    idle(5);
    chk("R8 released", int'(cs_n), 15);
  endtask

  task automatic t_odd_div();
    xfer(1, 8'h5A, 0, 8'hC3, 0);
    check_frame("odd", 8'h5A, 8'hC3, 5);
    chk("R5 lead cs1", first_rise - t_assert, eff(2) + half_of(5));
    idle(6);
  endtask

  task automatic t_fast();
    xfer(3, 8'h81, 0, 8'h7E, 0);
    check_frame("fast", 8'h81, 8'h7E, 1);
    chk("R5 zero lead", first_rise - t_assert, eff(0) + half_of(1));
    idle(4);
  endtask

  task automatic t_switch();
    xfer(0, 8'h12, 0, 8'h34, 0);
    check_frame("sw0", 8'h12, 8'h34, 4);
    xfer(1, 8'h56, 0, 8'h78, 0);
    check_frame("sw1", 8'h56, 8'h78, 5);
    chk("R6 switch gap", hi_len, eff(6) + 1);
    idle(6);
  endtask

  task automatic t_keep_same();
    xfer(0, 8'hF0, 1, 8'h0F, 0);
    check_frame("keep0", 8'hF0, 8'h0F, 4);
    xfer(0, 8'h99, 0, 8'h66, 0);
    check_frame("keep1", 8'h99, 8'h66, 4);
    chk("R8 no reassert", asserts, 0);
    chk("R8 held at ack", int'(cs_n[0]), 0);
    chk("R7 held spacing", lead_fall, 1 + eff(4) + half_of(4));
    idle(5);
    chk("R8 release after", int'(cs_n), 15);
  endtask

  task automatic t_same_released();
    xfer(0, 8'h01, 0, 8'h80, 0);
    check_frame("rel0", 8'h01, 8'h80, 4);
    xfer(0, 8'hFE, 0, 8'h7F, 0);
    check_frame("rel1", 8'hFE, 8'h7F, 4);
    chk("R7 released spacing", hi_len, 1 + eff(4));
    chk("R5 lead after trail", first_rise - t_assert, eff(3) + half_of(4));
    idle(5);
  endtask

  task automatic t_keep_then_other();
    xfer(0, 8'h3A, 1, 8'hA3, 0);
    check_frame("kt0", 8'h3A, 8'hA3, 4);
    idle(8);
    chk("R8 held while idle", int'(cs_n), 14);
    xfer(1, 8'hC5, 0, 8'h5C, 0);
    check_frame("kt1", 8'hC5, 8'h5C, 5);
    chk("R6 release at accept", hi_len, eff(6));
    idle(8);
  endtask

  task automatic t_cfg_change();
    xfer(3, 8'h6B, 0, 8'hB6, 1);
    check_frame("R9 captured", 8'h6B, 8'hB6, 1);
    chk("R9 lead kept", first_rise - t_assert, eff(0) + half_of(1));
    set_cfg(3, 1, 0, 0);
    idle(4);
  endtask

  initial begin
    set_cfg(0, 4, 3, 4);
    set_cfg(1, 5, 2, 3);
    set_cfg(2, 0, 1, 1);
    set_cfg(3, 1, 0, 0);
    cfg_swap_gap = 8'd6;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_zero_div();
    t_basic();
    t_odd_div();
    t_fast();
    t_switch();
    t_keep_same();
    t_same_released();
    t_keep_then_other();
    t_cfg_change();
    chk("R4 ack total", acks, 12);
    summary();
    $finish;
  end
endmodule